// File: doc/BRIEF.md
# Strap-Latched Frequency Source Selector

This block decides which frequency setting a clock synthesizer runs at. At power-up it captures a set of strap inputs (a 5-bit frequency code, a 2-bit drive-current select and a 2-bit output-frequency select) on the first cycle in which the active-low power-good input is low. After that capture the straps are frozen. Software then picks the active setting through a small byte-wide register file. It can leave the captured strap code in charge, or substitute its own 5-bit code, or switch to direct M/N divisor programming, where the VCO runs at 14.318 MHz × (N+4) / M.

A watchdog timeout input acts as a forced fallback. It drops direct M/N programming and reloads the frequency code. The reload source is either the captured straps or a 5-bit safe code that software stored in advance, and a safe-reload enable bit picks between them. The effective code is held in a register, so a software rewrite is seen downstream as a single clean change one cycle later.

Top module: `freq_src_sel`

## Requirements
- R1: After reset, the M divisor reads 5'b01101, the N divisor reads 9'h167, M/N mode is off, the software-code enable is off, the effective code is 0 and straps_valid is 0.
- R2: On the first clock edge after reset at which pg_n is 0, the block captures strap_fs, strap_cur and strap_osel and raises straps_valid.
- R3: Once straps_valid is 1, further changes on pg_n or on the strap inputs have no effect on the captured values.
- R4: With the software-code enable (register 0 bit 1) at 0, eff_code follows the captured strap code. With it at 1, eff_code follows the software code held in register 0 bits 6 to 2.
- R5: eff_code changes exactly one clock edge after the register write or capture that changes its source value.
- R6: Register 2 bit 7 holds N bit 8 and bits 4 to 0 hold M. Register 3 holds N bits 7 to 0. Register 4 bit 7 is the M/N enable and drives mn_mode.
- R7: Register 5 bits 1 to 0 hold the output select. A write to it is ignored until straps_valid is 1, and takes effect after that.
- R8: A wd_expire pulse clears M/N mode. With the safe-reload enable (register 0 bit 0) at 0, it clears the software-code enable, so the strap code becomes effective again.
- R9: A wd_expire pulse with the safe-reload enable at 1 copies the safe code (register 1 bits 4 to 0) into the software code and sets the software-code enable.
- R10: In a cycle with wd_expire high, any register write is dropped.
- R11: Register 6 reads {0, captured current select, captured code} and is read-only. Unused register 7 reads 0.
- R12: spread_en equals register 0 bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_n | input | 1 | Active-low power-good strobe that marks the straps as valid |
| strap_fs | input | 5 | Frequency code straps |
| strap_cur | input | 2 | Drive-current select straps |
| strap_osel | input | 2 | Output-frequency select straps |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| wd_expire | input | 1 | Watchdog timeout pulse |
| rd_data | output | 8 | Combinational read data |
| eff_code | output | 5 | Registered effective frequency code |
| m_div | output | 5 | M divisor |
| n_div | output | 9 | N divisor |
| mn_mode | output | 1 | Direct M/N programming active |
| spread_en | output | 1 | Spread-spectrum enable |
| cur_sel | output | 2 | Captured drive-current select |
| out_sel | output | 2 | Output-frequency select |
| straps_valid | output | 1 | Straps have been captured |

## Verification
The assertions assume that every input is steady around the rising clock edge and that wd_expire arrives as a pulse rather than a level. They also assume that reset is held over the first edges, so no property looks at values from before reset. The stimulus changes inputs only on falling edges and holds wd_expire high for exactly one cycle. Some sequences line a timeout up with a register write in the same cycle, and others toggle pg_n and the straps after capture to show that the captured values hold.

// File: rtl/fss_pkg.sv
package fss_pkg;

    localparam int CODE_W = 5;
    localparam int M_W    = 5;
    localparam int N_W    = 9;
    localparam int CUR_W  = 2;
    localparam int OSEL_W = 2;
    localparam int AW     = 3;
    localparam int DW     = 8;

    localparam logic [M_W-1:0] M_RST = 5'b01101;
    localparam logic [N_W-1:0] N_RST = 9'h167;

    typedef enum logic [AW-1:0] {
        A_CTRL  = 3'd0,
        A_SAFE  = 3'd1,
        A_MHI   = 3'd2,
        A_NLO   = 3'd3,
        A_MODE  = 3'd4,
        A_OSEL  = 3'd5,
        A_STRAP = 3'd6,
        A_NONE  = 3'd7
    } addr_e;

    typedef struct packed {
        logic              spread;
        logic [CODE_W-1:0] soft_code;
        logic              soft_en;
        logic              safe_en;
    } ctrl_t;

    typedef struct packed {
        logic [CODE_W-1:0] fs;
        logic [CUR_W-1:0]  cur;
    } strap_t;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
        logic           en;
    } divcfg_t;

    function automatic logic [DW-1:0] pack_strap(strap_t s);
        logic [DW-1:0] r;
        r = '0;
        r[CODE_W-1:0]              = s.fs;
        r[CODE_W+CUR_W-1:CODE_W]   = s.cur;
        return r;
    endfunction

    function automatic logic [DW-1:0] pack_mhi(divcfg_t d);
        logic [DW-1:0] r;
        r = '0;
        r[DW-1]    = d.n[N_W-1];
        r[M_W-1:0] = d.m;
        return r;
    endfunction

endpackage

// File: rtl/fss_strap_latch.sv
module fss_strap_latch
    import fss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_n,
    input  logic [CODE_W-1:0] strap_fs,
    input  logic [CUR_W-1:0]  strap_cur,
    input  logic [OSEL_W-1:0] strap_osel,
    input  logic              osel_we,
    input  logic [OSEL_W-1:0] osel_wdata,
    output logic              valid,
    output strap_t            lat,
    output logic [OSEL_W-1:0] osel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            lat   <= '0;
            osel  <= '0;
        end else if (!valid) begin
            if (!pg_n) begin
                valid  <= 1'b1;
                lat.fs <= strap_fs;
                lat.cur <= strap_cur;
                osel   <= strap_osel;
            end
        end else if (osel_we) begin
            osel <= osel_wdata;
        end
    end

endmodule

// File: rtl/fss_ctrl_regs.sv
module fss_ctrl_regs
    import fss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              wd_expire,
    output ctrl_t             ctrl,
    output logic [CODE_W-1:0] safe_code,
    output divcfg_t           div
);

    addr_e waddr;
    assign waddr = addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            safe_code <= '0;
            div.m     <= M_RST;
            div.n     <= N_RST;
            div.en    <= 1'b0;
        end else if (wd_expire) begin
            // fallback: leave direct programming, reload the code source
            div.en       <= 1'b0;
            ctrl.soft_en <= ctrl.safe_en;
            if (ctrl.safe_en) begin
                ctrl.soft_code <= safe_code;
            end
        end else if (wr_en) begin
            case (waddr)
                A_CTRL: ctrl <= ctrl_t'(wr_data);
                A_SAFE: safe_code <= wr_data[CODE_W-1:0];
                A_MHI: begin
                    div.n[N_W-1] <= wr_data[DW-1];
                    div.m        <= wr_data[M_W-1:0];
                end
                A_NLO:  div.n[N_W-2:0] <= wr_data[N_W-2:0];
                A_MODE: div.en <= wr_data[DW-1];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fss_code_sel.sv
module fss_code_sel
    import fss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_en,
    input  logic [CODE_W-1:0] soft_code,
    input  logic [CODE_W-1:0] strap_code,
    output logic [CODE_W-1:0] eff_code
);

    logic [CODE_W-1:0] next_code;

    always_comb begin
        next_code = soft_en ? soft_code : strap_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eff_code <= '0;
        end else begin
            eff_code <= next_code;
        end
    end

endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
    import fss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_n,
    input  logic [4:0]        strap_fs,
    input  logic [1:0]        strap_cur,
    input  logic [1:0]        strap_osel,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        rd_addr,
    input  logic              wd_expire,
    output logic [7:0]        rd_data,
    output logic [4:0]        eff_code,
    output logic [4:0]        m_div,
    output logic [8:0]        n_div,
    output logic              mn_mode,
    output logic              spread_en,
    output logic [1:0]        cur_sel,
    output logic [1:0]        out_sel,
    output logic              straps_valid
);

    ctrl_t             ctrl;
    divcfg_t           div;
    strap_t            lat;
    logic [CODE_W-1:0] safe_code;
    logic              osel_we;
    logic              soft_en;
    logic [CODE_W-1:0] soft_code;
    logic              safe_en;
    logic [CODE_W-1:0] lat_fs;

    assign osel_we = wr_en && !wd_expire && (addr_e'(wr_addr) == A_OSEL);

    fss_strap_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .pg_n       (pg_n),
        .strap_fs   (strap_fs),
        .strap_cur  (strap_cur),
        .strap_osel (strap_osel),
        .osel_we    (osel_we),
        .osel_wdata (wr_data[OSEL_W-1:0]),
        .valid      (straps_valid),
        .lat        (lat),
        .osel       (out_sel)
    );

    fss_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wd_expire (wd_expire),
        .ctrl      (ctrl),
        .safe_code (safe_code),
        .div       (div)
    );

    assign soft_en   = ctrl.soft_en;
    assign soft_code = ctrl.soft_code;
    assign safe_en   = ctrl.safe_en;
    assign lat_fs    = lat.fs;

    fss_code_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .soft_en    (soft_en),
        .soft_code  (soft_code),
        .strap_code (lat_fs),
        .eff_code   (eff_code)
    );

    assign m_div     = div.m;
    assign n_div     = div.n;
    assign mn_mode   = div.en;
    assign spread_en = ctrl.spread;
    assign cur_sel   = lat.cur;

    always_comb begin
        rd_data = '0;
        case (addr_e'(rd_addr))
            A_CTRL:  rd_data = DW'(ctrl);
            A_SAFE:  rd_data[CODE_W-1:0] = safe_code;
            A_MHI:   rd_data = pack_mhi(div);
            A_NLO:   rd_data = div.n[N_W-2:0];
            A_MODE:  rd_data[DW-1] = div.en;
            A_OSEL:  rd_data[OSEL_W-1:0] = out_sel;
            A_STRAP: rd_data = pack_strap(lat);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fss_checker.sv
module fss_checker (
    input logic       clk,
    input logic       rst,
    input logic       pg_n,
    input logic [4:0] strap_fs,
    input logic       wd_expire,
    input logic       straps_valid,
    input logic [4:0] lat_fs,
    input logic [1:0] out_sel,
    input logic       mn_mode,
    input logic       soft_en,
    input logic       safe_en,
    input logic [4:0] soft_code,
    input logic [4:0] safe_code
);

    // R2: first strobe captures the code straps
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (!straps_valid && !pg_n) |=> (straps_valid && lat_fs == $past(strap_fs)));

    // R3: captured code is frozen once valid
    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        straps_valid |=> (straps_valid && $stable(lat_fs)));

    // R7: output select untouched before capture
    a_r7_osel_locked: assert property (@(posedge clk) disable iff (rst)
        (!straps_valid && pg_n) |=> (!straps_valid && $stable(out_sel)));

    // R8: timeout leaves direct divisor mode
    a_r8_mn_cleared: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> !mn_mode);

    // R9: safe reload installs the safe code
    a_r9_safe_reload: assert property (@(posedge clk) disable iff (rst)
        (wd_expire && safe_en) |=> (soft_en && soft_code == $past(safe_code)));

    // R10: writes are dropped during a timeout
    a_r10_write_dropped: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> ($stable(safe_code) && $stable(safe_en)));

endmodule

bind freq_src_sel fss_checker u_fss_chk (
    .clk          (clk),
    .rst          (rst),
    .pg_n         (pg_n),
    .strap_fs     (strap_fs),
    .wd_expire    (wd_expire),
    .straps_valid (straps_valid),
    .lat_fs       (lat_fs),
    .out_sel      (out_sel),
    .mn_mode      (mn_mode),
    .soft_en      (soft_en),
    .safe_en      (safe_en),
    .soft_code    (soft_code),
    .safe_code    (safe_code)
);

// File: tb/test_freq_src_sel.sv
module test_freq_src_sel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pg_n = 1'b1;
    logic [4:0] strap_fs = 5'b10110;
    logic [1:0] strap_cur = 2'b10;
    logic [1:0] strap_osel = 2'b01;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] rd_addr = 3'd0;
    logic       wd_expire = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] eff_code, m_div;
    logic [8:0] n_div;
    logic       mn_mode, spread_en, straps_valid;
    logic [1:0] cur_sel, out_sel;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    freq_src_sel i_freq_src_sel (.*);

    always #5 clk = ~clk;

    // behavioural reference state
    int m_cap, m_fs, m_cur, m_osel, m_spr, m_soft, m_sen, m_safe_en, m_safe;
    int m_m, m_n, m_mn, m_eff;

    function automatic int model_read(int a);
        case (a)
            0: return m_spr * 128 + m_soft * 4 + m_sen * 2 + m_safe_en;
            1: return m_safe;
            2: return (m_n / 256) * 128 + m_m;
            3: return m_n % 256;
            4: return m_mn * 128;
            5: return m_osel;
            6: return m_cur * 32 + m_fs;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int n_eff;
        int o_cap;
        cyc++;
        if (rst) begin
            m_cap = 0; m_fs = 0; m_cur = 0; m_osel = 0; m_spr = 0; m_soft = 0;
            m_sen = 0; m_safe_en = 0; m_safe = 0; m_m = 13; m_n = 'h167; m_mn = 0; m_eff = 0;
        end else begin
            n_eff = m_sen ? m_soft : m_fs;
            o_cap = m_cap;
            if (!o_cap && !pg_n) begin
                m_cap = 1; m_fs = strap_fs; m_cur = strap_cur; m_osel = strap_osel;
            end
            if (wd_expire) begin
                m_mn = 0;
                if (m_safe_en) begin m_sen = 1; m_soft = m_safe; end
                else m_sen = 0;
            end else if (wr_en) begin
                case (wr_addr)
                    0: begin m_spr = wr_data[7]; m_soft = wr_data[6:2];
                             m_sen = wr_data[1]; m_safe_en = wr_data[0]; end
                    1: m_safe = wr_data[4:0];
                    2: begin m_n = wr_data[7] * 256 + (m_n % 256); m_m = wr_data[4:0]; end
                    3: m_n = (m_n / 256) * 256 + wr_data;
                    4: m_mn = wr_data[7];
                    5: if (o_cap) m_osel = wr_data[1:0];
                    default: ;
                endcase
            end
            m_eff = n_eff;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk("R4 R5 eff_code", eff_code, m_eff);
            chk("R6 m_div", m_div, m_m);
            chk("R6 n_div", n_div, m_n);
            chk("R6 R8 mn_mode", mn_mode, m_mn);
            chk("R12 spread_en", spread_en, m_spr);
            chk("R2 cur_sel", cur_sel, m_cur);
            chk("R7 out_sel", out_sel, m_osel);
            chk("R2 straps_valid", straps_valid, m_cap);
            chk("R11 rd_data", rd_data, model_read(rd_addr));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d, bit wd);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d); wd_expire = wd;
        @(negedge clk);
        wr_en = 1'b0; wd_expire = 1'b0;
    endtask

    task automatic wd_pulse();
        @(negedge clk);
        wd_expire = 1'b1;
        @(negedge clk);
        wd_expire = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        rd_addr = 3'(a);
        #1;
        v = rd_data;
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1);
        chk("R1 m reset", m_div, 5'b01101);
        chk("R1 n reset", n_div, 9'h167);
        chk("R1 mn reset", mn_mode, 0);
        chk("R1 eff reset", eff_code, 0);
        chk("R1 valid reset", straps_valid, 0);
        rd(0, v); chk("R1 soft enable reset", v[1], 0);

        wr(5, 3, 0);
        step(1);
        chk("R7 osel write before capture", out_sel, 0);

        @(negedge clk); pg_n = 1'b0;
        @(negedge clk); pg_n = 1'b1;
        chk("R2 valid", straps_valid, 1);
        chk("R2 osel captured", out_sel, 2'b01);
        rd(6, v); chk("R2 R11 strap readback", v, 8'h56);
        step(1);
        chk("R4 strap code effective", eff_code, 5'b10110);

        strap_fs = 5'b00001; strap_cur = 2'b01; strap_osel = 2'b11;
        @(negedge clk); pg_n = 1'b0;
        step(2); pg_n = 1'b1;
        step(1);
        chk("R3 code held", eff_code, 5'b10110);
        rd(6, v); chk("R3 readback held", v, 8'h56);
        chk("R3 osel held", out_sel, 2'b01);

        wr(0, 8'hAE, 0);
        chk("R5 eff unchanged one edge after write", eff_code, 5'b10110);
        step(1);
        chk("R4 R5 soft code effective", eff_code, 5'b01011);
        chk("R12 spread set", spread_en, 1);

        wr(2, 8'h87, 0); wr(3, 8'h2A, 0); wr(4, 8'h80, 0);
        step(1);
        chk("R6 m", m_div, 7);
        chk("R6 n", n_div, 9'h12A);
        chk("R6 mn_mode", mn_mode, 1);

        wr(5, 2, 0);
        chk("R7 osel write after capture", out_sel, 2);

        wr(6, 8'hFF, 0);
        rd(6, v); chk("R11 strap reg read-only", v, 8'h56);
        rd(7, v); chk("R11 unused reads zero", v, 0);

        wd_pulse();
        chk("R8 mn cleared", mn_mode, 0);
        rd(0, v); chk("R8 soft enable cleared", v, 8'hAC);
        step(1);
        chk("R8 strap code restored", eff_code, 5'b10110);

        wr(1, 3, 0); wr(0, 8'hAD, 0); wr(4, 8'h80, 0);
        wd_pulse();
        rd(0, v); chk("R9 safe code loaded", v, 8'h8F);
        step(1);
        chk("R9 safe code effective", eff_code, 5'b00011);

        wr(1, 8'h1F, 1);
        rd(1, v); chk("R10 write dropped on timeout", v, 3);
        wr(0, 8'h00, 1);
        rd(0, v); chk("R10 ctrl write dropped", v, 8'h8F);
        chk("R12 spread kept", spread_en, 1);

        rd_addr = 3'd0;
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); rd_addr = 3'(a);
        end
        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule